// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial clock of an SPI master from the system clock. The division ratio is the product of a prescaler value and a scaler value. Each value is picked from a small fixed set by its own select field. A double-rate input halves the scaler's share of the division, so the serial clock runs at twice the rate. The shift logic next to the block does not watch the serial clock itself. It acts on two one-cycle strobes, one when the clock leaves its idle level and one when it returns to it.

Inside the same block, a second counter produces a periodic delay tick. It divides the system clock by the same prescaler and scaler product, but it ignores the double-rate input. A sequencer outside the block counts these ticks to time the gaps between transfers.

The select fields and the double-rate bit are captured only while the block is disabled. A change made while it runs waits for the next enable. The serial clock runs only while both the enable and the run control are high.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, `sck` sits at its idle level (0 by default) and `lead_stb`, `trail_stb` and `dly_tick` are all 0.
- R2: The prescaler select `pre_sel` maps codes 0, 1, 2 and 3 to divide values 2, 3, 5 and 7.
- R3: The scaler select `scl_sel` maps codes 0 to 3 to divide values 2, 4, 6 and 8, and any code k from 4 upward to 2 to the power k (16 up to 32768).
- R4: With `dbl_rate` at 0, the serial clock period P is prescaler times scaler system clocks, and each half of the period lasts P/2 cycles.
- R5: With `dbl_rate` at 1, P is half of prescaler times scaler. The active (non-idle) phase lasts floor(P/2) cycles and the idle phase lasts the rest, so an odd P makes the active phase one cycle shorter.
- R6: The idle level of `sck` holds until the first clock edge, which comes a full idle phase after the first cycle in which `en` and `run` are both sampled high. `lead_stb` is high for exactly the cycle in which `sck` has just moved to its active level. `trail_stb` is high for exactly the cycle in which `sck` has just returned to idle. The two strobes are never high together.
- R7: Once `run` or `en` is sampled low, `sck` returns to idle one cycle later and no strobe is issued.
- R8: `pre_sel`, `scl_sel` and `dbl_rate` are sampled only while `en` is low. Changing them while `en` is high has no effect on the running clock.
- R9: While `en` is high, `dly_tick` is a one-cycle pulse every prescaler-times-scaler system clocks, counted from the first cycle `en` is sampled high. It is independent of `run` and `dbl_rate`.
- R10: One cycle after `en` is sampled low, `dly_tick` is 0, and its count starts again at the next enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; the rate fields are captured while it is low |
| run | input | 1 | Start/stop control for the serial clock |
| pre_sel | input | 2 | Prescaler select code |
| scl_sel | input | 4 | Scaler select code |
| dbl_rate | input | 1 | Double-rate select |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on each idle-to-active edge of sck |
| trail_stb | output | 1 | One-cycle strobe on each active-to-idle edge of sck |
| dly_tick | output | 1 | One-cycle tick for timing transfer delays |

## Verification
The delay tick and a serial clock strobe can fall in the same system cycle.

- With double-rate clear, the tick period equals the serial clock period.
- So when `en` and `run` rise together, every trailing strobe lands on the same cycle as a tick.

The bench provokes this with the smallest division and judges each output separately. A queue holds the expected edge gaps, and a separate counter holds the expected tick period. The bench also confirms that at least one such shared cycle occurred.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

   // Prescaler divide value for a select code.
   function automatic int unsigned pre_div(input int unsigned sel);
      case (sel)
         0: pre_div = 2;
         1: pre_div = 3;
         2: pre_div = 5;
         default: pre_div = 7;
      endcase
   endfunction

   // Scaler divide value: linear steps for the low codes, powers of two above.
   function automatic int unsigned scl_div(input int unsigned sel);
      if (sel < 4) scl_div = 2 * (sel + 1);
      else         scl_div = 32'd1 << sel;
   endfunction

endpackage

// File: rtl/spi_baud_cfg.sv
module spi_baud_cfg
   import spi_baud_pkg::*;
#(
   parameter int PSEL_W = 2,
   parameter int SSEL_W = 4,
   parameter int CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PSEL_W-1:0] pre_sel,
   input  logic [SSEL_W-1:0] scl_sel,
   input  logic              dbl_rate,
   output logic [PSEL_W-1:0] cap_pre,
   output logic [SSEL_W-1:0] cap_scl,
   output logic              cap_dbl,
   output logic [CNT_W-1:0]  act_len,
   output logic [CNT_W-1:0]  idle_len,
   output logic [CNT_W-1:0]  dly_len
);

   logic [CNT_W-1:0] full_div;
   logic [CNT_W-1:0] per_len;

   // Fields track the inputs while disabled and freeze while enabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_pre <= '0;
         cap_scl <= '0;
         cap_dbl <= 1'b0;
      end else if (!en) begin
         cap_pre <= pre_sel;
         cap_scl <= scl_sel;
         cap_dbl <= dbl_rate;
      end
   end

   // Phase lengths come from frozen fields, so this path is static while running.
   always_comb begin
      full_div = CNT_W'(pre_div(32'(cap_pre)) * scl_div(32'(cap_scl)));
      per_len  = cap_dbl ? (full_div >> 1) : full_div;
      act_len  = per_len >> 1;
      idle_len = per_len - act_len;
      dly_len  = full_div;
   end

endmodule

// File: rtl/spi_baud_sck.sv
module spi_baud_sck #(
   parameter int   CNT_W    = 18,
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] act_len,
   input  logic [CNT_W-1:0] idle_len,
   output logic             sck,
   output logic             lead_stb,
   output logic             trail_stb
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nx;
   logic [CNT_W-1:0] ph_len;
   logic             in_act;

   assign cnt_nx = cnt + 1'b1;
   assign ph_len = in_act ? act_len : idle_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         in_act    <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!active) begin
         cnt       <= '0;
         in_act    <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (cnt_nx == ph_len) begin
         cnt       <= '0;
         in_act    <= ~in_act;
         lead_stb  <= ~in_act;
         trail_stb <= in_act;
      end else begin
         cnt       <= cnt_nx;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end
   end

   // Output polarity is fixed at elaboration.
   if (IDLE_LVL) begin : g_idle_high
      assign sck = ~in_act;
   end else begin : g_idle_low
      assign sck = in_act;
   end

endmodule

// File: rtl/spi_baud_dly.sv
module spi_baud_dly #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] dly_len,
   output logic             dly_tick
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nx;

   assign cnt_nx = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         dly_tick <= 1'b0;
      end else if (!en) begin
         cnt      <= '0;
         dly_tick <= 1'b0;
      end else if (cnt_nx == dly_len) begin
         cnt      <= '0;
         dly_tick <= 1'b1;
      end else begin
         cnt      <= cnt_nx;
         dly_tick <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int   PSEL_W   = 2,
   parameter int   SSEL_W   = 4,
   parameter int   CNT_W    = 18,
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              run,
   input  logic [PSEL_W-1:0] pre_sel,
   input  logic [SSEL_W-1:0] scl_sel,
   input  logic              dbl_rate,
   output logic              sck,
   output logic              lead_stb,
   output logic              trail_stb,
   output logic              dly_tick
);

   localparam longint MAX_SCL = (SSEL_W > 2) ? (64'd1 << ((1 << SSEL_W) - 1))
                                             : 64'(2 * (1 << SSEL_W));
   localparam longint MAX_DIV = 7 * MAX_SCL;

   if (PSEL_W != 2) begin : g_bad_psel
      $error("spi_baud_gen: PSEL_W must be 2");
   end
   if (SSEL_W < 1 || SSEL_W > 4) begin : g_bad_ssel
      $error("spi_baud_gen: SSEL_W must lie in 1..4");
   end
   if (MAX_DIV >= (64'd1 << CNT_W)) begin : g_bad_cnt
      $error("spi_baud_gen: CNT_W too narrow for the largest division");
   end

   logic              active;
   logic [PSEL_W-1:0] cap_pre;
   logic [SSEL_W-1:0] cap_scl;
   logic              cap_dbl;
   logic [CNT_W-1:0]  act_len;
   logic [CNT_W-1:0]  idle_len;
   logic [CNT_W-1:0]  dly_len;

   assign active = en & run;

   spi_baud_cfg #(
      .PSEL_W (PSEL_W),
      .SSEL_W (SSEL_W),
      .CNT_W  (CNT_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .pre_sel  (pre_sel),
      .scl_sel  (scl_sel),
      .dbl_rate (dbl_rate),
      .cap_pre  (cap_pre),
      .cap_scl  (cap_scl),
      .cap_dbl  (cap_dbl),
      .act_len  (act_len),
      .idle_len (idle_len),
      .dly_len  (dly_len)
   );

   spi_baud_sck #(
      .CNT_W    (CNT_W),
      .IDLE_LVL (IDLE_LVL)
   ) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .act_len   (act_len),
      .idle_len  (idle_len),
      .sck       (sck),
      .lead_stb  (lead_stb),
      .trail_stb (trail_stb)
   );

   spi_baud_dly #(
      .CNT_W (CNT_W)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .dly_len  (dly_len),
      .dly_tick (dly_tick)
   );

endmodule

// File: rtl/spi_baud_gen_chk.sv
module spi_baud_gen_chk #(
   parameter int   PSEL_W   = 2,
   parameter int   SSEL_W   = 4,
   parameter logic IDLE_LVL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              run,
   input logic              sck,
   input logic              lead_stb,
   input logic              trail_stb,
   input logic              dly_tick,
   input logic [PSEL_W-1:0] cfg_pre,
   input logic [SSEL_W-1:0] cfg_scl,
   input logic              cfg_dbl
);

   assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || !run) |=> (sck == IDLE_LVL) && !lead_stb && !trail_stb);

   assert_tick_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !dly_tick);

   assert_lead_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sck != IDLE_LVL) && ($past(sck) == IDLE_LVL));

   assert_trail_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |-> (sck == IDLE_LVL) && ($past(sck) != IDLE_LVL));

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   assert_edge_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en && run) && (sck != $past(sck))) |-> (lead_stb || trail_stb));

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> ($stable(cfg_pre) && $stable(cfg_scl) && $stable(cfg_dbl)));

endmodule

bind spi_baud_gen spi_baud_gen_chk #(
   .PSEL_W   (PSEL_W),
   .SSEL_W   (SSEL_W),
   .IDLE_LVL (IDLE_LVL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .run       (run),
   .sck       (sck),
   .lead_stb  (lead_stb),
   .trail_stb (trail_stb),
   .dly_tick  (dly_tick),
   .cfg_pre   (cap_pre),
   .cfg_scl   (cap_scl),
   .cfg_dbl   (cap_dbl)
);

// File: tb/spi_baud_gen_test.sv
`timescale 1ns/1ps
module spi_baud_gen_test;

   typedef struct {
      int gap;
      bit lead;
      string tag;
   } edge_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       run = 1'b0;
   logic [1:0] pre_sel = '0;
   logic [3:0] scl_sel = '0;
   logic       dbl_rate = 1'b0;
   logic       sck, lead_stb, trail_stb, dly_tick;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cur_q = 0;
   int    coinc = 0;
   edge_t exp_q[$];

   always #4 clk = ~clk;

   spi_baud_gen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .run       (run),
      .pre_sel   (pre_sel),
      .scl_sel   (scl_sel),
      .dbl_rate  (dbl_rate),
      .sck       (sck),
      .lead_stb  (lead_stb),
      .trail_stb (trail_stb),
      .dly_tick  (dly_tick)
   );

   function automatic int pre_of(input int s);
      case (s)
         0: return 2;
         1: return 3;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int scl_of(input int s);
      if (s < 4) return 2 * (s + 1);
      return 1 << s;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Monitor: measures gaps between strobes and between ticks.
   initial begin
      int  gap = 0;
      int  tgap = 0;
      bit  act_prev = 0;
      bit  en_prev = 0;
      edge_t e;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (act_prev) gap++;
            if (en_prev) tgap++;
            if (lead_stb || trail_stb) begin
               if (exp_q.size() > 0) begin
                  e = exp_q.pop_front();
                  check(gap == e.gap, e.tag, gap, e.gap);
                  check(lead_stb == e.lead && sck == e.lead && !(lead_stb && trail_stb),
                        "R6 strobe kind / sck level", int'(lead_stb), int'(e.lead));
               end
               gap = 0;
            end
            if (dly_tick) begin
               check(tgap == cur_q, "R9 tick period", tgap, cur_q);
               if (trail_stb || lead_stb) coinc++;
               tgap = 0;
            end else if (en_prev && cur_q > 0 && tgap > cur_q) begin
               check(1'b0, "R9 missing tick", tgap, cur_q);
               tgap = 0;
            end
            if (!(en && run)) gap = 0;
            if (!en) tgap = 0;
            act_prev = en && run;
            en_prev  = en;
         end
      end
   end

   // Driver: sets up one rate, queues the expected edges, starts and stops.
   task automatic run_case(input int ps, input int ss, input int d, input int n,
                           input bit scramble, input bit stop_by_en);
      int q, p, hi, lo;
      string tg;
      @(negedge clk);
      en <= 1'b0; run <= 1'b0;
      pre_sel <= 2'(ps); scl_sel <= 4'(ss); dbl_rate <= 1'(d);
      repeat (2) @(negedge clk);
      q  = pre_of(ps) * scl_of(ss);
      p  = d ? q / 2 : q;
      hi = p / 2;
      lo = p - hi;
      cur_q = q;
      tg = d ? $sformatf("R5 R2/R3 phase pre=%0d scl=%0d", ps, ss)
             : $sformatf("R4 R2/R3 phase pre=%0d scl=%0d", ps, ss);
      for (int i = 0; i < n; i++) begin
         edge_t e;
         e.gap  = (i % 2 == 0) ? lo : hi;
         e.lead = (i % 2 == 0);
         e.tag  = tg;
         exp_q.push_back(e);
      end
      en <= 1'b1; run <= 1'b1;
      if (scramble) begin
         // R8: field changes while enabled must not disturb the queued timing.
         @(negedge clk);
         pre_sel <= ~2'(ps); scl_sel <= 4'(ss) ^ 4'd1; dbl_rate <= ~1'(d);
      end
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      if (stop_by_en) en <= 1'b0;
      else            run <= 1'b0;
      @(negedge clk);
      #2;
      check(sck == 1'b0 && !lead_stb && !trail_stb, "R7 idle after stop",
            int'(sck) + 2 * int'(lead_stb || trail_stb), 0);
      if (stop_by_en) check(!dly_tick, "R10 tick quiet when disabled", int'(dly_tick), 0);
      @(negedge clk);
      en <= 1'b0; run <= 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check(sck == 1'b0 && !lead_stb && !trail_stb && !dly_tick, "R1 reset outputs",
            int'({sck, lead_stb, trail_stb, dly_tick}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      check(sck == 1'b0 && !lead_stb && !trail_stb && !dly_tick, "R1 after release",
            int'({sck, lead_stb, trail_stb, dly_tick}), 0);

      run_case(0, 0,  0, 8, 0, 0);   // P=4, tick period 4: trailing edges meet ticks
      run_case(1, 0,  1, 8, 0, 1);   // P=3: active 1, idle 2
      run_case(3, 2,  1, 6, 1, 0);   // P=21: active 10, idle 11, fields scrambled
      run_case(2, 4,  0, 4, 0, 0);   // P=80
      run_case(0, 7,  0, 2, 0, 0);   // P=256
      run_case(1, 3,  1, 4, 0, 0);   // P=12
      run_case(3, 15, 1, 1, 0, 0);   // largest code: first idle phase 57344

      check(coinc > 0, "R9 tick shares a cycle with trail_stb", coinc, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule